// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers 72 level-sensitive interrupt lines into three banks and presents them to a single processor through a small register interface. Two banks of 32 lines come from a shared subsystem. The third bank of 8 lines is local to the processor. Each bank has a set-enable register and a clear-enable register. Each shared bank also has a read-only masked pending register.

A summary register gives the masked pending state of the local bank and one "more pending" flag per shared bank. It also carries direct shortcut copies of a few selected shared sources. Handler software can often pick its source from this single read and skip the per-bank pending reads.

Pending state is never latched: a pending bit follows its input line while that line's enable is set. A single registered IRQ output is raised whenever any enabled source is active.

The register port is a plain synchronous write strobe with a combinational read path. Addresses are byte addresses and are decoded in full.

| Address | Register |
|---|---|
| 0x00 | summary (read-only) |
| 0x04 | shared bank A masked pending (read-only) |
| 0x08 | shared bank B masked pending (read-only) |
| 0x10 / 0x14 / 0x18 | set-enable for bank A / bank B / local bank; a read returns the enable state |
| 0x20 / 0x24 / 0x28 | clear-enable for bank A / bank B / local bank; a read returns 0 |

Top module: `lvl_intc`

## Requirements
- R1: Reset clears every enable bit. After reset the enable reads at 0x10, 0x14 and 0x18 return 0, and irq_o stays low even with all sources high.
- R2: A write to set-enable address 0x10 (sources 0..31), 0x14 (sources 32..63) or 0x18 (sources 64..71, data bits 7:0) sets the enable of every bit written as 1. Bits written as 0 keep their enable. Reading the same address returns the bank's enable state, zero-extended to 32 bits.
- R3: A write to clear-enable address 0x20, 0x24 or 0x28 (same bank order as R2) clears the enable of every bit written as 1. Bits written as 0 keep their enable.
- R4: A read of 0x04 returns sources 0..31 AND their enables. A read of 0x08 returns sources 32..63 AND their enables (bit n is source 32+n). Both follow the inputs in the same cycle, with nothing latched.
- R5: Writes to 0x00, 0x04, 0x08 or to any unmapped address change no enable. Reads of unmapped addresses and of the clear-enable addresses return 0.
- R6: Summary register (0x00) bits 7:0 are local sources 64..71 AND their enables.
- R7: Summary bit 8 is set when any enabled source in 0..31 is high. Summary bit 9 is set when any enabled source in 32..63 is high. This holds for sources that also have a shortcut bit.
- R8: Summary bits 14:10 copy the masked pending state of sources 7, 9, 10, 18, 19, in that order from bit 10. Bits 20:15 copy sources 53, 54, 55, 56, 57, 62, in that order from bit 15. Bits 31:21 read 0.
- R9: irq_o is a register. It is high in the cycle after a clock edge at which any source was high with its enable set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| src_i | input | 72 | level interrupt lines, index = source number |
| reg_wr | input | 1 | write strobe, sampled at the rising edge |
| reg_addr | input | 6 | byte address for reads and writes |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data for reg_addr, combinational |
| irq_o | output | 1 | registered interrupt request |

## Verification
The bench walks every one of the 72 sources on its own through enable, pending, release and disable. A wrong bank offset or a shortcut wired to the wrong source therefore shows up as a misplaced bit in the summary or the pending reads. It checks that a shortcut source still raises its bank flag, because a design that steals the source from the flag would leave bit 8 or 9 low. Dropping a line right after it was seen pending catches a latched pending bit. Long random sequences of mixed set and clear writes catch an enable register that overwrites where it should OR or AND-NOT. A latency probe catches an IRQ that is combinational or two cycles late.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;
    localparam int A_W = 6;
    localparam int DW  = 32;

    localparam logic [A_W-1:0] A_SUMMARY = 6'h00;
    localparam logic [A_W-1:0] A_PEND_A  = 6'h04;
    localparam logic [A_W-1:0] A_PEND_B  = 6'h08;
    localparam logic [A_W-1:0] A_SET_EN  = 6'h10;
    localparam logic [A_W-1:0] A_CLR_EN  = 6'h20;

    typedef enum logic [1:0] {
        BANK_A   = 2'd0,
        BANK_B   = 2'd1,
        BANK_LOC = 2'd2
    } bank_e;

    function automatic logic [A_W-1:0] bank_off(input bank_e b);
        return A_W'({b, 2'b00});
    endfunction
endpackage

// File: rtl/lvl_intc_en_bank.sv
module lvl_intc_en_bank import lvl_intc_pkg::*; #(
    parameter int W = 32,
    parameter logic [A_W-1:0] SET_ADDR = 6'h10,
    parameter logic [A_W-1:0] CLR_ADDR = 6'h20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [A_W-1:0] addr,
    input  logic [W-1:0]   wdata,
    output logic [W-1:0]   en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= '0;
        end else if (wr && addr == SET_ADDR) begin
            en <= en | wdata;
        end else if (wr && addr == CLR_ADDR) begin
            en <= en & ~wdata;
        end
    end
endmodule

// File: rtl/lvl_intc_summary.sv
module lvl_intc_summary import lvl_intc_pkg::*; #(
    parameter int NS   = 32,
    parameter int NL   = 8,
    parameter int NSC1 = 5,
    parameter int NSC2 = 6,
    parameter logic [NSC1*8-1:0] SC1_IDX = {8'd19, 8'd18, 8'd10, 8'd9, 8'd7},
    parameter logic [NSC2*8-1:0] SC2_IDX = {8'd30, 8'd25, 8'd24, 8'd23, 8'd22, 8'd21}
) (
    input  logic [NS-1:0] pend_a,
    input  logic [NS-1:0] pend_b,
    input  logic [NL-1:0] pend_l,
    output logic [DW-1:0] summary
);
    localparam int IW    = $clog2(NS);
    localparam int B_FA  = NL;
    localparam int B_FB  = NL + 1;
    localparam int B_SC1 = NL + 2;
    localparam int B_SC2 = B_SC1 + NSC1;
    localparam int USED  = B_SC2 + NSC2;

    assign summary[NL-1:0] = pend_l;
    assign summary[B_FA]   = |pend_a;
    assign summary[B_FB]   = |pend_b;

    for (genvar k = 0; k < NSC1; k++) begin : g_sc_a
        assign summary[B_SC1+k] = pend_a[SC1_IDX[k*8 +: IW]];
    end
    for (genvar k = 0; k < NSC2; k++) begin : g_sc_b
        assign summary[B_SC2+k] = pend_b[SC2_IDX[k*8 +: IW]];
    end
    if (USED < DW) begin : g_pad
        assign summary[DW-1:USED] = '0;
    end
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc import lvl_intc_pkg::*; #(
    parameter int NS   = 32,
    parameter int NL   = 8,
    parameter int NSC1 = 5,
    parameter int NSC2 = 6,
    parameter logic [NSC1*8-1:0] SC1_IDX = {8'd19, 8'd18, 8'd10, 8'd9, 8'd7},
    parameter logic [NSC2*8-1:0] SC2_IDX = {8'd30, 8'd25, 8'd24, 8'd23, 8'd22, 8'd21}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*NS+NL-1:0] src_i,
    input  logic              reg_wr,
    input  logic [A_W-1:0]    reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq_o
);
    localparam int NSRC = 2 * NS + NL;

    logic [NSRC-1:0] en_all;
    logic [NS-1:0]   pend_a, pend_b;
    logic [NL-1:0]   pend_l;
    logic [DW-1:0]   summary;
    logic            irq_q;

    for (genvar b = 0; b < 3; b++) begin : g_bank
        localparam int BW = (b == 2) ? NL : NS;
        logic [BW-1:0] bank_en;
        lvl_intc_en_bank #(
            .W        (BW),
            .SET_ADDR (A_SET_EN + bank_off(bank_e'(b))),
            .CLR_ADDR (A_CLR_EN + bank_off(bank_e'(b)))
        ) u_en (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (reg_wr),
            .addr  (reg_addr),
            .wdata (reg_wdata[BW-1:0]),
            .en    (bank_en)
        );
        assign en_all[b*NS +: BW] = bank_en;
    end

    assign pend_a = src_i[NS-1:0]    & en_all[NS-1:0];
    assign pend_b = src_i[2*NS-1:NS] & en_all[2*NS-1:NS];
    assign pend_l = src_i[NSRC-1 -: NL] & en_all[NSRC-1 -: NL];

    lvl_intc_summary #(
        .NS(NS), .NL(NL), .NSC1(NSC1), .NSC2(NSC2),
        .SC1_IDX(SC1_IDX), .SC2_IDX(SC2_IDX)
    ) u_sum (
        .pend_a  (pend_a),
        .pend_b  (pend_b),
        .pend_l  (pend_l),
        .summary (summary)
    );

    always_comb begin
        case (reg_addr)
            A_SUMMARY:                         reg_rdata = summary;
            A_PEND_A:                          reg_rdata = DW'(pend_a);
            A_PEND_B:                          reg_rdata = DW'(pend_b);
            A_SET_EN + bank_off(BANK_A):       reg_rdata = DW'(en_all[NS-1:0]);
            A_SET_EN + bank_off(BANK_B):       reg_rdata = DW'(en_all[2*NS-1:NS]);
            A_SET_EN + bank_off(BANK_LOC):     reg_rdata = DW'(en_all[NSRC-1 -: NL]);
            default:                           reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |{pend_a, pend_b, pend_l};
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk import lvl_intc_pkg::*; #(
    parameter int NS = 32,
    parameter int NL = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*NS+NL-1:0]  src_i,
    input logic                reg_wr,
    input logic [A_W-1:0]      reg_addr,
    input logic [DW-1:0]       reg_wdata,
    input logic [NL-1:0]       rd_low,
    input logic                irq_o,
    input logic [2*NS+NL-1:0]  en_all
);
    localparam int NSRC = 2 * NS + NL;

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SET_EN) |=>
        ((en_all[NS-1:0] & $past(reg_wdata[NS-1:0])) == $past(reg_wdata[NS-1:0])));

    // R2
    en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SET_EN + 6'h4) |=>
        ((en_all[2*NS-1:NS] & ~$past(reg_wdata[NS-1:0])) ==
         ($past(en_all[2*NS-1:NS]) & ~$past(reg_wdata[NS-1:0]))));

    // R3
    dis_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLR_EN + 6'h8) |=>
        ((en_all[NSRC-1 -: NL] & $past(reg_wdata[NL-1:0])) == '0));

    // R5
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_SUMMARY || reg_addr == A_PEND_A || reg_addr == A_PEND_B))
        |=> $stable(en_all));

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|src_i));

    // R9
    irq_noen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_all) == '0) |-> !irq_o);

    // R6
    loc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_SUMMARY && en_all[NSRC-1 -: NL] == '0) |-> (rd_low == '0));
endmodule

bind lvl_intc lvl_intc_chk #(.NS(NS), .NL(NL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rd_low    (reg_rdata[NL-1:0]),
    .irq_o     (irq_o),
    .en_all    (en_all)
);

// File: tb/test_lvl_intc.sv
module test_lvl_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [71:0] src_i = '0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [71:0] en_m = '0;
    bit done = 0;

    lvl_intc i_lvl_intc (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_summary();
        int sa[5] = '{7, 9, 10, 18, 19};
        int sb[6] = '{53, 54, 55, 56, 57, 62};
        logic [71:0] p = src_i & en_m;
        logic [31:0] s = '0;
        s[7:0] = p[71:64];
        s[8] = |p[31:0];
        s[9] = |p[63:32];
        for (int k = 0; k < 5; k++) s[10+k] = p[sa[k]];
        for (int k = 0; k < 6; k++) s[15+k] = p[sb[k]];
        return s;
    endfunction

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            6'h00: return exp_summary();
            6'h04: return src_i[31:0] & en_m[31:0];
            6'h08: return src_i[63:32] & en_m[63:32];
            6'h10: return en_m[31:0];
            6'h14: return en_m[63:32];
            6'h18: return {24'h0, en_m[71:64]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic rd_chk(input logic [5:0] a, input string req);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp_read(a));
    endtask

    task automatic chk_all();
        rd_chk(6'h00, "R6 R7 R8 summary");
        rd_chk(6'h04, "R4 pend A");
        rd_chk(6'h08, "R4 pend B");
        rd_chk(6'h10, "R2 R3 en A");
        rd_chk(6'h14, "R2 R3 en B");
        rd_chk(6'h18, "R2 R3 en L");
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            6'h10: en_m[31:0]  = en_m[31:0] | d;
            6'h14: en_m[63:32] = en_m[63:32] | d;
            6'h18: en_m[71:64] = en_m[71:64] | d[7:0];
            6'h20: en_m[31:0]  = en_m[31:0] & ~d;
            6'h24: en_m[63:32] = en_m[63:32] & ~d;
            6'h28: en_m[71:64] = en_m[71:64] & ~d[7:0];
            default: ;
        endcase
    endtask

    task automatic chk_irq(input string req);
        @(negedge clk);
        check(req, {31'h0, irq_o}, {31'h0, |(src_i & en_m)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        src_i = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_chk(6'h10, "R1 en A after reset");
        rd_chk(6'h14, "R1 en B after reset");
        rd_chk(6'h18, "R1 en L after reset");
        @(negedge clk);
        check("R1 irq after reset", {31'h0, irq_o}, 32'h0);
        src_i = '0;

        // R2 R3 R4 R6 R7 R8 R9: every source on its own
        for (int i = 0; i < 72; i++) begin
            int b = (i < 32) ? 0 : (i < 64) ? 1 : 2;
            int bit_n = i - 32 * b;
            wr(6'h10 + 6'(4 * b), 32'h1 << bit_n);
            src_i = '0; src_i[i] = 1'b1;
            chk_all();
            chk_irq("R9 single source on");
            src_i = '0;
            rd_chk(6'h00, "R4 R6 level not latched summary");
            rd_chk(6'h04, "R4 level not latched A");
            rd_chk(6'h08, "R4 level not latched B");
            wr(6'h20 + 6'(4 * b), 32'h1 << bit_n);
            src_i[i] = 1'b1;
            chk_all();
            chk_irq("R3 R9 disabled source");
            src_i = '0;
        end

        // R5: writes to read-only and unmapped addresses
        wr(6'h10, 32'hA5A5_0F0F);
        wr(6'h14, 32'h3C3C_F00D);
        wr(6'h18, 32'h0000_0069);
        wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h08, 32'hFFFF_FFFF);
        wr(6'h3C, 32'hFFFF_FFFF);
        wr(6'h1C, 32'hFFFF_FFFF);
        rd_chk(6'h10, "R5 en A unchanged");
        rd_chk(6'h14, "R5 en B unchanged");
        rd_chk(6'h18, "R5 en L unchanged");
        rd_chk(6'h24, "R5 clear address reads 0");
        rd_chk(6'h30, "R5 unmapped reads 0");

        // R7: shortcut sources also set bank flags
        wr(6'h10, 32'h0000_0080);
        src_i = '0; src_i[7] = 1'b1;
        reg_addr = 6'h00; #1;
        check("R7 flag with shortcut A", {31'h0, reg_rdata[8]}, 32'h1);
        check("R8 shortcut A bit 10", {31'h0, reg_rdata[10]}, 32'h1);
        src_i = '0; src_i[62] = 1'b1;
        wr(6'h14, 32'h4000_0000);
        reg_addr = 6'h00; #1;
        check("R7 flag with shortcut B", {31'h0, reg_rdata[9]}, 32'h1);
        check("R8 shortcut B bit 20", {31'h0, reg_rdata[20]}, 32'h1);

        // R9: one cycle latency
        wr(6'h28, 32'hFF);
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h24, 32'hFFFF_FFFF);
        src_i = '0;
        wr(6'h18, 32'h01);
        @(negedge clk);
        src_i[64] = 1'b1;
        #2;
        check("R9 irq not yet", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        check("R9 irq after one edge", {31'h0, irq_o}, 32'h1);
        src_i[64] = 1'b0;
        #2;
        check("R9 irq holds until edge", {31'h0, irq_o}, 32'h1);
        @(negedge clk);
        check("R9 irq drops", {31'h0, irq_o}, 32'h0);

        // R2 R3 R4 R6 R7 R8 R9: random mix
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom % 6);
            logic [31:0] d = $urandom;
            if (it % 3 == 0) d = d & $urandom;
            wr(op < 3 ? 6'h10 + 6'(4 * op) : 6'h20 + 6'(4 * (op - 3)), d);
            src_i = {$urandom, $urandom, $urandom};
            if (it % 4 == 0) src_i = src_i & {$urandom, $urandom, $urandom};
            chk_all();
            chk_irq("R9 random irq");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule